// File: doc/BRIEF.md
# Serial Flash Host Command Sequencer

This block sits between a simple request port and a serial flash attached over a four-wire SPI link in mode 0. A client asks for one operation at a time: plain read, fast read, single-byte program, one of four erase sizes, manufacturer/device identification or status read. Each request carries an address, one write byte and a count of bytes to return. The sequencer builds the correct transaction for that request. It sends the opcode, then the address and dummy bytes the opcode needs, and then streams the returned bytes to the client through a valid/ready handshake.

For the operations that change the flash array, the sequencer first sends a separate write-enable transaction on its own. After the modifying transaction it reads the status register over and over until the busy flag is clear. A one-cycle `done` pulse closes every request. The SCK half period comes from one of two divider inputs: a slower one for the plain read opcode and a faster one for everything else. Chip select always stays high for a programmable number of clocks between transactions.

Top module: `spi_flash_seq`

## Requirements
- R1: While reset is held and after it, chip select is high, SCK is low, `req_ready` is high, `rd_valid` and `done` are low.
- R2: `req_op` selects the opcode byte: 0 read 0x03, 1 fast read 0x0B, 2 byte program 0x02, 3 4 KB erase 0x20, 4 32 KB erase 0x52, 5 64 KB erase 0xD8, 6 chip erase 0x60, 7 identification 0x9F, 8 status read 0x05.
- R3: Read, program and the three sized erases send `req_addr` as three bytes after the opcode, high byte first. Fast read then sends one 0x00 dummy byte, and program then sends `req_wdata`. Chip erase, identification and status read send the opcode alone before data.
- R4: SCK idles low and is low when chip select falls. Every byte goes out MSB first, and MOSI changes only while SCK is low, so it is stable at each rising edge. MISO is sampled on the rising edge.
- R5: SCK high and low phases each last `div_slow` system clocks during a plain read (op 0), and `div_fast` clocks for every other transaction (both at least 1).
- R6: Chip select stays high for at least `cs_gap` system clocks between any two transactions. It rises only after a whole number of bytes, right after the final byte.
- R7: Each modifying operation (ops 2 to 6) is preceded by its own transaction made of the single byte 0x06.
- R8: After a modifying transaction, the block repeats two-byte transactions (0x05 plus one returned byte) until bit 0 of the returned byte is 0, and only then finishes.
- R9: Read-type operations (ops 0, 1, 7, 8) return exactly `req_len` bytes on `rd_data`, each held with `rd_valid` until `rd_ready`. SCK stays low while a byte waits. A count of 0 sends the header only.
- R10: `req_ready` is low from acceptance to completion, and requests offered in that time are ignored.
- R11: `done` is a single-cycle pulse that closes every accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request accepted when high with `req_valid` |
| req_op | input | 4 | Operation code (0..8; 9..15 act as status read) |
| req_addr | input | 24 | Flash byte address |
| req_wdata | input | 8 | Byte to program |
| req_len | input | LEN_W | Bytes to return for read-type operations |
| rd_valid | output | 1 | Returned byte available |
| rd_ready | input | 1 | Client takes returned byte |
| rd_data | output | 8 | Returned byte |
| done | output | 1 | Request complete pulse |
| div_fast | input | DIV_W | SCK half period in clocks, normal opcodes |
| div_slow | input | DIV_W | SCK half period in clocks, plain read |
| cs_gap | input | GAP_W | Minimum chip-select high time in clocks |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Data to flash |
| spi_miso | input | 1 | Data from flash |

## Verification
If the transaction state is wrong, the flash-side log shows it within one transaction. A missing write-enable, a wrong header length or an extra poll changes the number of transactions and their byte counts, which the bench compares after each request. A bad returned-byte count or a bad handshake state shows on `rd_valid` at the next byte. A divider or gap counter that is off shows up in the measured SCK phase and chip-select high time during the same request. A poll loop that reads the wrong status bit either ends early, which gives fewer polls, or never ends, which trips the watchdog.

// File: rtl/spiseq_pkg.sv
// Shared types for the serial flash sequencer.
// Assumes: request codes 9..15 are reserved and decode as status read.
package spiseq_pkg;

    typedef enum logic [3:0] {
        OP_READ       = 4'd0,
        OP_FAST       = 4'd1,
        OP_PROG       = 4'd2,
        OP_ERASE_4K   = 4'd3,
        OP_ERASE_32K  = 4'd4,
        OP_ERASE_64K  = 4'd5,
        OP_ERASE_CHIP = 4'd6,
        OP_IDENT      = 4'd7,
        OP_STATUS     = 4'd8
    } op_e;

    typedef enum logic [1:0] {
        T_WREN,
        T_MAIN,
        T_POLL
    } trn_e;

    localparam logic [7:0] CMD_WREN   = 8'h06;
    localparam logic [7:0] CMD_STATUS = 8'h05;

    // Operations that alter the array and need enable plus busy polling.
    function automatic logic op_is_mod(op_e op);
        return (op == OP_PROG) || (op == OP_ERASE_4K) || (op == OP_ERASE_32K) ||
               (op == OP_ERASE_64K) || (op == OP_ERASE_CHIP);
    endfunction

endpackage

// File: rtl/spiseq_decode.sv
// Header builder: gives the header length and the header byte at a given
// index for the current transaction type and operation.
// Assumes: idx counts header bytes from 0 (opcode first).
module spiseq_decode
    import spiseq_pkg::*;
(
    input  op_e         op,
    input  trn_e        trn,
    input  logic [23:0] addr,
    input  logic [7:0]  wdata,
    input  logic [2:0]  idx,
    output logic [2:0]  hdr_len,
    output logic [7:0]  hdr_byte
);

    logic [7:0] opc;

    // Opcode byte for each operation.
    always_comb begin
        case (op)
            OP_READ:       opc = 8'h03;
            OP_FAST:       opc = 8'h0B;
            OP_PROG:       opc = 8'h02;
            OP_ERASE_4K:   opc = 8'h20;
            OP_ERASE_32K:  opc = 8'h52;
            OP_ERASE_64K:  opc = 8'hD8;
            OP_ERASE_CHIP: opc = 8'h60;
            OP_IDENT:      opc = 8'h9F;
            default:       opc = CMD_STATUS;
        endcase
    end

    // Header length: opcode, optional address, optional dummy or write byte.
    always_comb begin
        if (trn != T_MAIN) begin
            hdr_len = 3'd1;
        end else begin
            case (op)
                OP_FAST, OP_PROG:                                    hdr_len = 3'd5;
                OP_READ, OP_ERASE_4K, OP_ERASE_32K, OP_ERASE_64K:    hdr_len = 3'd4;
                default:                                             hdr_len = 3'd1;
            endcase
        end
    end

    // Byte at position idx of the header.
    always_comb begin
        case (idx)
            3'd0:    hdr_byte = (trn == T_WREN) ? CMD_WREN :
                                (trn == T_POLL) ? CMD_STATUS : opc;
            3'd1:    hdr_byte = addr[23:16];
            3'd2:    hdr_byte = addr[15:8];
            3'd3:    hdr_byte = addr[7:0];
            default: hdr_byte = (op == OP_PROG) ? wdata : 8'h00;
        endcase
    end

endmodule

// File: rtl/spiseq_shifter.sv
// One-byte mode-0 SPI engine: on start, shifts tx out MSB first with SCK
// phases of 'half' clocks, samples MISO on each rising edge, pulses done
// once SCK has fallen after the eighth bit.
// Assumes: half >= 1; start is only raised while not busy.
module spiseq_shifter #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [7:0]       tx,
    input  logic [DIV_W-1:0] half,
    input  logic             miso,
    output logic             sck,
    output logic             mosi,
    output logic             busy,
    output logic             done,
    output logic [7:0]       rx
);

    logic             active;
    logic             sck_q;
    logic             done_q;
    logic [7:0]       sh;
    logic [7:0]       rx_q;
    logic [2:0]       bitn;
    logic [DIV_W-1:0] cnt;
    logic [DIV_W:0]   cnt_nx;
    logic             phase_end;

    assign cnt_nx    = {1'b0, cnt} + {{DIV_W{1'b0}}, 1'b1};
    assign phase_end = (cnt_nx >= {1'b0, half});

    // Bit engine: phase timing, SCK toggling, shift out and sample in.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            sck_q  <= 1'b0;
            done_q <= 1'b0;
            sh     <= 8'h00;
            rx_q   <= 8'h00;
            bitn   <= 3'd0;
            cnt    <= '0;
        end else begin
            done_q <= 1'b0;
            if (start && !active) begin
                active <= 1'b1;
                sh     <= tx;
                bitn   <= 3'd0;
                cnt    <= '0;
            end else if (active) begin
                if (phase_end) begin
                    cnt <= '0;
                    if (!sck_q) begin
                        sck_q <= 1'b1;
                        rx_q  <= {rx_q[6:0], miso};
                    end else begin
                        sck_q <= 1'b0;
                        sh    <= {sh[6:0], 1'b0};
                        if (bitn == 3'd7) begin
                            active <= 1'b0;
                            done_q <= 1'b1;
                        end else begin
                            bitn <= bitn + 3'd1;
                        end
                    end
                end else begin
                    cnt <= cnt_nx[DIV_W-1:0];
                end
            end
        end
    end

    assign sck  = sck_q;
    assign mosi = active ? sh[7] : 1'b0;
    assign busy = active;
    assign done = done_q;
    assign rx   = rx_q;

    // MOSI must not move on the cycle SCK rises.
    p_mosi_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sck_q) |-> $stable(mosi));

    // SCK is only high while a byte is in flight.
    p_sck_in_byte_r4: assert property (@(posedge clk) disable iff (!rst_n)
        sck_q |-> active);

endmodule

// File: rtl/spi_flash_seq.sv
// Serial flash host command sequencer: accepts one request, inserts the
// write-enable transaction for modifying operations, runs the main
// transaction, polls status until not busy, streams read bytes out.
// Assumes: div_fast, div_slow >= 1; client holds request fields with req_valid.
module spi_flash_seq
    import spiseq_pkg::*;
#(
    parameter int DIV_W = 8,
    parameter int GAP_W = 8,
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [3:0]       req_op,
    input  logic [23:0]      req_addr,
    input  logic [7:0]       req_wdata,
    input  logic [LEN_W-1:0] req_len,
    output logic             rd_valid,
    input  logic             rd_ready,
    output logic [7:0]       rd_data,
    output logic             done,
    input  logic [DIV_W-1:0] div_fast,
    input  logic [DIV_W-1:0] div_slow,
    input  logic [GAP_W-1:0] cs_gap,
    output logic             spi_cs_n,
    output logic             spi_sck,
    output logic             spi_mosi,
    input  logic             spi_miso
);

    typedef enum logic [2:0] {S_IDLE, S_GAP, S_NEXT, S_XFER, S_RDOUT, S_END} st_e;

    st_e              st;
    trn_e             trn;
    op_e              op_q;
    logic [23:0]      addr_q;
    logic [7:0]       wd_q;
    logic [LEN_W-1:0] rem;
    logic [2:0]       idx;
    logic [GAP_W-1:0] gap_cnt;
    logic             cs_q;
    logic             done_q;
    logic [7:0]       rd_q;
    logic             rxph;
    logic             stat_busy;

    logic [2:0]       hdr_len;
    logic [7:0]       hdr_byte;
    logic             in_hdr;
    logic             eng_start;
    logic [7:0]       eng_tx;
    logic [DIV_W-1:0] eng_half;
    logic             eng_busy;
    logic             eng_done;
    logic [7:0]       eng_rx;
    op_e              req_op_e;

    assign req_op_e  = op_e'(req_op);
    assign in_hdr    = (idx < hdr_len);
    assign eng_start = (st == S_NEXT) && (in_hdr || (rem != '0));
    assign eng_tx    = in_hdr ? hdr_byte : 8'h00;
    assign eng_half  = (op_q == OP_READ) ? div_slow : div_fast;

    spiseq_decode i_decode (
        .op       (op_q),
        .trn      (trn),
        .addr     (addr_q),
        .wdata    (wd_q),
        .idx      (idx),
        .hdr_len  (hdr_len),
        .hdr_byte (hdr_byte)
    );

    spiseq_shifter #(.DIV_W(DIV_W)) i_shifter (
        .clk   (clk),
        .rst_n (rst_n),
        .start (eng_start),
        .tx    (eng_tx),
        .half  (eng_half),
        .miso  (spi_miso),
        .sck   (spi_sck),
        .mosi  (spi_mosi),
        .busy  (eng_busy),
        .done  (eng_done),
        .rx    (eng_rx)
    );

    // Request and transaction sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= S_IDLE;
            trn       <= T_MAIN;
            op_q      <= OP_READ;
            addr_q    <= '0;
            wd_q      <= '0;
            rem       <= '0;
            idx       <= '0;
            gap_cnt   <= '0;
            cs_q      <= 1'b1;
            done_q    <= 1'b0;
            rd_q      <= '0;
            rxph      <= 1'b0;
            stat_busy <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (st)
                S_IDLE: if (req_valid) begin
                    op_q    <= req_op_e;
                    addr_q  <= req_addr;
                    wd_q    <= req_wdata;
                    trn     <= op_is_mod(req_op_e) ? T_WREN : T_MAIN;
                    rem     <= op_is_mod(req_op_e) ? '0 : req_len;
                    idx     <= '0;
                    gap_cnt <= '0;
                    st      <= S_GAP;
                end
                S_GAP: begin
                    if (gap_cnt >= cs_gap) begin
                        cs_q <= 1'b0;
                        idx  <= '0;
                        st   <= S_NEXT;
                    end else begin
                        gap_cnt <= gap_cnt + GAP_W'(1);
                    end
                end
                S_NEXT: begin
                    if (in_hdr) begin
                        idx  <= idx + 3'd1;
                        rxph <= 1'b0;
                        st   <= S_XFER;
                    end else if (rem != '0) begin
                        rxph <= 1'b1;
                        st   <= S_XFER;
                    end else begin
                        st <= S_END;
                    end
                end
                S_XFER: if (eng_done) begin
                    if (rxph) begin
                        rem <= rem - LEN_W'(1);
                        if (trn == T_POLL) begin
                            stat_busy <= eng_rx[0];
                            st        <= S_NEXT;
                        end else begin
                            rd_q <= eng_rx;
                            st   <= S_RDOUT;
                        end
                    end else begin
                        st <= S_NEXT;
                    end
                end
                S_RDOUT: if (rd_ready) st <= S_NEXT;
                S_END: begin
                    cs_q    <= 1'b1;
                    gap_cnt <= '0;
                    if (trn == T_WREN) begin
                        trn <= T_MAIN;
                        st  <= S_GAP;
                    end else if ((trn == T_MAIN && op_is_mod(op_q)) ||
                                 (trn == T_POLL && stat_busy)) begin
                        trn <= T_POLL;
                        rem <= LEN_W'(1);
                        st  <= S_GAP;
                    end else begin
                        done_q <= 1'b1;
                        st     <= S_IDLE;
                    end
                end
                default: st <= S_IDLE;
            endcase
        end
    end

    assign req_ready = (st == S_IDLE);
    assign rd_valid  = (st == S_RDOUT);
    assign rd_data   = rd_q;
    assign done      = done_q;
    assign spi_cs_n  = cs_q;

    // Chip select only rises between bytes.
    p_cs_byte_edge_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(spi_cs_n) |-> !eng_busy && !spi_sck);

    // SCK idles low whenever the flash is deselected.
    p_sck_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> !spi_sck);

    // A waiting returned byte stays put until taken.
    p_rd_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid && !rd_ready |=> rd_valid && $stable(rd_data));

    // Accepting a request closes the request port.
    p_ready_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> !req_ready);

    // Completion is a single cycle wide.
    p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // No SCK activity while a returned byte is waiting.
    p_stall_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> !eng_busy);

endmodule

// File: tb/test_spi_flash_seq.sv
// Bench for spi_flash_seq: a behavioural flash model logs every
// transaction; a vector table drives each operation, then directed tests.
module test_spi_flash_seq;

    localparam int CLK_PERIOD = 10;
    localparam int DIV_FAST   = 2;
    localparam int DIV_SLOW   = 4;
    localparam int CS_GAP     = 5;
    localparam int NVEC       = 9;

    // {op[59:56], addr[55:32], wdata[31:24], len[23:16], busy[15:12], hdr[11:8], opcode[7:0]}
    localparam logic [59:0] VECS [NVEC] = '{
        {4'd0, 24'h123456, 8'h00, 8'd4, 4'd0, 4'd4, 8'h03},
        {4'd1, 24'hABCDEF, 8'h00, 8'd3, 4'd0, 4'd5, 8'h0B},
        {4'd2, 24'h00F0E1, 8'hA7, 8'd0, 4'd2, 4'd5, 8'h02},
        {4'd3, 24'h012000, 8'h00, 8'd0, 4'd1, 4'd4, 8'h20},
        {4'd4, 24'h3F8000, 8'h00, 8'd0, 4'd0, 4'd4, 8'h52},
        {4'd5, 24'h7F0000, 8'h00, 8'd0, 4'd3, 4'd4, 8'hD8},
        {4'd6, 24'h000000, 8'h00, 8'd0, 4'd1, 4'd1, 8'h60},
        {4'd7, 24'h000000, 8'h00, 8'd3, 4'd0, 4'd1, 8'h9F},
        {4'd8, 24'h000000, 8'h00, 8'd2, 4'd0, 4'd1, 8'h05}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [3:0]  req_op = '0;
    logic [23:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic [15:0] req_len = '0;
    logic        rd_valid;
    logic        rd_ready = 1'b1;
    logic [7:0]  rd_data;
    logic        done;
    logic        spi_cs_n;
    logic        spi_sck;
    logic        spi_mosi;
    logic        spi_miso = 1'b1;

    int checks = 0;
    int fails = 0;
    bit finished = 1'b0;

    spi_flash_seq i_spi_flash_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_op    (req_op),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .req_len   (req_len),
        .rd_valid  (rd_valid),
        .rd_ready  (rd_ready),
        .rd_data   (rd_data),
        .done      (done),
        .div_fast  (8'(DIV_FAST)),
        .div_slow  (8'(DIV_SLOW)),
        .cs_gap    (8'(CS_GAP)),
        .spi_cs_n  (spi_cs_n),
        .spi_sck   (spi_sck),
        .spi_mosi  (spi_mosi),
        .spi_miso  (spi_miso)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // ---------------- flash model ----------------
    int         rcnt = 0;
    logic [7:0] cur = 8'h00;
    logic [7:0] resp_sh = 8'hFF;
    logic [7:0] blog [16];
    int         ntrn = 0;
    logic [7:0] trn_b [32][8];
    int         trn_n [32];
    int         partial = 0;
    int         wel_viol = 0;
    int         mode_viol = 0;
    int         busy_left = 0;
    int         busy_cfg = 0;
    bit         wel = 1'b0;

    function automatic int hdrlen(logic [7:0] opc);
        case (opc)
            8'h0B, 8'h02:               return 5;
            8'h03, 8'h20, 8'h52, 8'hD8: return 4;
            default:                    return 1;
        endcase
    endfunction

    function automatic logic [7:0] pat(logic [7:0] opc, int k);
        return (8'h3C + 8'(k * 7)) ^ opc;
    endfunction

    function automatic bit is_mod(logic [7:0] opc);
        return opc == 8'h02 || opc == 8'h20 || opc == 8'h52 || opc == 8'hD8 || opc == 8'h60;
    endfunction

    always @(negedge spi_cs_n) if (spi_sck === 1'b1) mode_viol++;

    always @(posedge spi_sck or posedge spi_cs_n) begin
        if (spi_cs_n) begin
            if (rcnt > 0) begin
                if (rcnt % 8 != 0) partial++;
                if (ntrn < 32) begin
                    trn_n[ntrn] = rcnt / 8;
                    for (int i = 0; i < 8; i++) trn_b[ntrn][i] = blog[i];
                end
                ntrn++;
                if (blog[0] == 8'h06 && rcnt == 8) wel = 1'b1;
                if (is_mod(blog[0])) begin
                    if (!wel) wel_viol++;
                    wel = 1'b0;
                    busy_left = busy_cfg;
                end
                if (blog[0] == 8'h05 && busy_left > 0) busy_left--;
            end
            rcnt = 0;
        end else begin
            cur = {cur[6:0], spi_mosi};
            rcnt++;
            if (rcnt % 8 == 0) begin
                int b;
                b = rcnt / 8;
                if (b <= 16) blog[b-1] = cur;
                if (b < hdrlen(blog[0])) resp_sh = 8'hFF;
                else if (blog[0] == 8'h05) resp_sh = (busy_left > 0) ? 8'h1D : 8'h1C;
                else resp_sh = pat(blog[0], b - hdrlen(blog[0]));
                spi_miso = resp_sh[7];
            end else begin
                spi_miso = resp_sh[7 - (rcnt % 8)];
            end
        end
    end

    // ---------------- port monitors ----------------
    logic [7:0] rxb [16];
    int rxn = 0;
    int hi_run = 0, hi_min = 1000, hi_max = 0;
    int cs_run = 0, gap_min = 100000;

    always @(negedge clk) begin
        if (rd_valid && rd_ready) begin
            if (rxn < 16) rxb[rxn] = rd_data;
            rxn++;
        end
        if (spi_sck) hi_run++;
        else if (hi_run != 0) begin
            if (hi_run < hi_min) hi_min = hi_run;
            if (hi_run > hi_max) hi_max = hi_run;
            hi_run = 0;
        end
        if (spi_cs_n) cs_run++;
        else if (cs_run != 0) begin
            if (cs_run < gap_min) gap_min = cs_run;
            cs_run = 0;
        end
    end

    // ---------------- helpers ----------------
    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clear_logs();
        ntrn = 0; rxn = 0; partial = 0; wel_viol = 0; mode_viol = 0;
        hi_min = 1000; hi_max = 0; gap_min = 100000;
    endtask

    task automatic start_req(input logic [3:0] op, input logic [23:0] a,
                             input logic [7:0] wd, input int len);
        @(negedge clk);
        clear_logs();
        req_op = op; req_addr = a; req_wdata = wd; req_len = 16'(len);
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_done(input string req);
        int t;
        t = 0;
        while (!done && t < 20000) begin
            @(negedge clk);
            t++;
        end
        chk(done === 1'b1, req, done, 1);
        @(negedge clk);
        chk(done === 1'b0, "R11 done pulse width", done, 0);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    // ---------------- main ----------------
    initial begin
        repeat (4) @(negedge clk);
        // R1 reset state while held
        chk(spi_cs_n === 1'b1, "R1 cs_n in reset", spi_cs_n, 1);
        chk(spi_sck === 1'b0, "R1 sck in reset", spi_sck, 0);
        chk(req_ready === 1'b1 && rd_valid === 1'b0 && done === 1'b0,
            "R1 handshake in reset", {req_ready, rd_valid, done}, 3'b100);
        rst_n = 1'b1;
        @(negedge clk);
        chk(spi_cs_n === 1'b1 && req_ready === 1'b1, "R1 after reset", {spi_cs_n, req_ready}, 2'b11);

        for (int v = 0; v < NVEC; v++) begin
            logic [3:0]  op;
            logic [23:0] a;
            logic [7:0]  wd, opc;
            int len, bz, hdr, mi, nexp, half;
            bit md;
            op = VECS[v][59:56]; a = VECS[v][55:32]; wd = VECS[v][31:24];
            len = int'(VECS[v][23:16]); bz = int'(VECS[v][15:12]);
            hdr = int'(VECS[v][11:8]); opc = VECS[v][7:0];
            md = (op >= 4'd2 && op <= 4'd6);
            mi = md ? 1 : 0;
            nexp = md ? bz + 3 : 1;
            half = (op == 4'd0) ? DIV_SLOW : DIV_FAST;
            busy_cfg = bz;
            start_req(op, a, wd, len);
            wait_done("R11 done after request");
            chk(ntrn == nexp, "R8 transaction count", ntrn, nexp);
            if (md) begin
                chk(trn_b[0][0] == 8'h06 && trn_n[0] == 1, "R7 write enable first",
                    {trn_b[0][0], 8'(trn_n[0])}, 16'h0601);
                for (int p = 0; p <= bz; p++)
                    chk(trn_b[mi+1+p][0] == 8'h05 && trn_n[mi+1+p] == 2, "R8 status poll",
                        {trn_b[mi+1+p][0], 8'(trn_n[mi+1+p])}, 16'h0502);
            end
            chk(trn_b[mi][0] == opc, "R2 opcode", trn_b[mi][0], opc);
            chk(trn_n[mi] == hdr + len, "R3 transaction length", trn_n[mi], hdr + len);
            if (hdr >= 4)
                chk({trn_b[mi][1], trn_b[mi][2], trn_b[mi][3]} == a, "R3 R4 address MSB first",
                    {trn_b[mi][1], trn_b[mi][2], trn_b[mi][3]}, a);
            if (op == 4'd1) chk(trn_b[mi][4] == 8'h00, "R3 dummy byte", trn_b[mi][4], 0);
            if (op == 4'd2) chk(trn_b[mi][4] == wd, "R3 program byte", trn_b[mi][4], wd);
            chk(rxn == len, "R9 returned byte count", rxn, len);
            for (int k = 0; k < len; k++) begin
                logic [7:0] e;
                e = (op == 4'd8) ? 8'h1C : pat(opc, k);
                chk(rxb[k] == e, "R9 returned data", rxb[k], e);
            end
            chk(hi_min == half && hi_max == half, "R5 SCK half period", hi_max, half);
            chk(gap_min >= CS_GAP, "R6 cs high gap", gap_min, CS_GAP);
            chk(partial == 0, "R6 whole bytes only", partial, 0);
            chk(mode_viol == 0, "R4 sck low at select", mode_viol, 0);
            chk(wel_viol == 0, "R7 enable before modify", wel_viol, 0);
        end

        // R9 backpressure: byte held, SCK quiet
        busy_cfg = 0;
        rd_ready = 1'b0;
        start_req(4'd0, 24'h000010, 8'h00, 2);
        for (int t = 0; t < 5000 && !rd_valid; t++) @(negedge clk);
        chk(rd_valid === 1'b1, "R9 byte offered", rd_valid, 1);
        for (int t = 0; t < 10; t++) begin
            @(negedge clk);
            chk(rd_valid === 1'b1 && rd_data == pat(8'h03, 0) && spi_sck === 1'b0,
                "R9 stall hold", rd_data, pat(8'h03, 0));
        end
        rd_ready = 1'b1;
        wait_done("R11 done after stall");
        chk(rxn == 2 && rxb[1] == pat(8'h03, 1), "R9 data after stall", rxb[1], pat(8'h03, 1));

        // R10 requests ignored while busy
        busy_cfg = 4;
        start_req(4'd6, 24'h0, 8'h00, 0);
        chk(req_ready === 1'b0, "R10 ready low during op", req_ready, 0);
        req_op = 4'd0; req_len = 16'd3; req_valid = 1'b1;
        repeat (40) @(negedge clk);
        req_valid = 1'b0;
        wait_done("R11 done after chip erase");
        chk(ntrn == 7, "R8 R10 chip erase transactions", ntrn, 7);
        repeat (100) @(negedge clk);
        chk(ntrn == 7 && rxn == 0, "R10 offered request ignored", ntrn, 7);
        chk(req_ready === 1'b1, "R10 ready back", req_ready, 1);

        // R9 zero count read sends header only
        busy_cfg = 0;
        start_req(4'd0, 24'h00ABCD, 8'h00, 0);
        wait_done("R11 done zero count");
        chk(ntrn == 1 && trn_n[0] == 4 && rxn == 0, "R9 zero count", trn_n[0], 4);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule